// File: doc/BRIEF.md
# Packed Lane Shuffle Network

A combinational permutation unit for a packed-data datapath. It takes two 64-bit source vectors and a 5-bit shuffle code and assembles a 64-bit result. The result is made either from eight byte lanes or from four halfword lanes. Each result lane is a chosen lane of one of the two sources. For byte shuffles, a result lane can also be a sign-fill byte derived from a lane of the first source.

The shuffle code carries both the lane format and the pattern. The available patterns are fixed: interleave of the upper or lower halves, pack of odd or even lanes, halfword butterfly, halfword replicate, and byte sign-unpack. A code that names no pattern raises the illegal flag and forces the result to zero. Lane 0 is always the least significant lane, both in the sources and in the result.

The unit sits between a packed register read stage and a writeback stage. It has no state, so every result is valid in the same cycle as its inputs.

Top module: `lsh_shuffle_unit`

## Requirements
- R1: Format decoding. Code bits [1:0] = 01 select halfword lanes, with the pattern index in code[4:2]. Code bit 0 = 0 selects byte lanes, with the pattern index in code[4:1]. Code bits [1:0] = 11 are illegal.
- R2: The following codes set `illegal` to 1 and drive `result` to zero whatever the sources hold:
  - halfword indices 3 and 5 (codes 0x0D and 0x15);
  - byte index 0 (code 0x00);
  - byte indices 8 to 15 (even codes 0x10 to 0x1E);
  - any code with bits [1:0] = 11.
- R3: Halfword mix-high (code 0x01) gives, from lane 0 upward: second lane 2, first lane 2, second lane 3, first lane 3. Halfword mix-low (code 0x05) gives the same order using lanes 0 and 1.
- R4: Halfword pack-high (code 0x09) gives second lanes 1 and 3, then first lanes 1 and 3. Halfword butterfly (code 0x11) gives second lane 1, first lane 0, second lane 3, first lane 2.
- R5: Halfword replicate-high (code 0x19) gives second lanes 2 and 3, then first lanes 2 and 3. Halfword replicate-low (code 0x1D) gives second lanes 0 and 1, then first lanes 0 and 1.
- R6: Byte interleave-high (codes 0x02 and 0x0C) gives second lane k, then first lane k, for k = 4 to 7. Byte interleave-low (codes 0x04 and 0x0E) does the same for k = 0 to 3.
- R7: Byte pack-high (code 0x08) gives the odd lanes of the second source in ascending order, then the odd lanes of the first source. Byte pack-low (code 0x0A) does the same with the even lanes.
- R8: Byte sign-unpack (code 0x06) gives first lane k followed by a fill byte, for k = 0 to 3. The fill byte is 0xFF when bit 7 of first lane k is set and 0x00 otherwise. The second source has no effect on the result.
- R9: Lane 0 occupies bits [7:0] (byte) or [15:0] (halfword) of each source and of the result.
- R10: Every one of the 13 legal codes drives `illegal` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shuf_code | input | 5 | Shuffle code: lane format and pattern |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| result | output | 64 | Shuffled vector, zero when the code is illegal |
| illegal | output | 1 | High for a reserved or undefined code |

## Verification
The hardest case to isolate is a lane taken from the wrong source, or from a neighbouring index, while still matching by accident. To rule this out, the sources carry a distinct byte value in every lane of both vectors (first source 0xA0 to 0xA7, second source 0xB0 to 0xB7). A wrong pick then always changes the result. The sign-unpack fill is reached with a first source whose lanes 0 to 3 mix set and clear bit 7. The same code is then applied again with a different second source, which shows that the second source is ignored. A sweep over all 32 codes with all-ones sources checks the illegal decoding and the zero forcing.

// File: rtl/lsh_shuffle_pkg.sv
// Package: shared widths, pattern and source-select types for the shuffle unit.
// Assumes a 64-bit vector split into 8-bit or 16-bit lanes.
package lsh_shuffle_pkg;

    localparam int DATA_W   = 64;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int CODE_W   = 5;
    localparam int NBYTES   = DATA_W / BYTE_W;
    localparam int NHALVES  = DATA_W / HALF_W;

    // Lane placement patterns shared by both lane formats.
    typedef enum logic [3:0] {
        PAT_NONE,
        PAT_MIX_HI,
        PAT_MIX_LO,
        PAT_UNPK_SGN,
        PAT_PACK_HI,
        PAT_PACK_LO,
        PAT_BFLY,
        PAT_REP_HI,
        PAT_REP_LO
    } pattern_e;

    // Where a result lane comes from.
    typedef enum logic [1:0] {
        SRC_FIRST,
        SRC_SECOND,
        SRC_SIGN
    } src_e;

endpackage

// File: rtl/lsh_code_decode.sv
// Module: decodes a shuffle code into a lane format, a pattern and an illegal flag.
// Assumes the code layout: [1:0]=01 halfword, [0]=0 byte, [1:0]=11 illegal.
module lsh_code_decode
    import lsh_shuffle_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic              is_half,
    output pattern_e          pattern,
    output logic              bad_code
);

    localparam int HIDX_W = CODE_W - 2;
    localparam int BIDX_W = CODE_W - 1;

    logic [HIDX_W-1:0] half_idx;
    logic [BIDX_W-1:0] byte_idx;
    logic              fmt_half;
    logic              fmt_byte;
    pattern_e          half_pat;
    pattern_e          byte_pat;

    assign half_idx = code[CODE_W-1:2];
    assign byte_idx = code[CODE_W-1:1];
    assign fmt_half = (code[1:0] == 2'b01);
    assign fmt_byte = ~code[0];

    // Map the halfword table index to a pattern.
    always_comb begin
        case (half_idx)
            3'd0:    half_pat = PAT_MIX_HI;
            3'd1:    half_pat = PAT_MIX_LO;
            3'd2:    half_pat = PAT_PACK_HI;
            3'd4:    half_pat = PAT_BFLY;
            3'd6:    half_pat = PAT_REP_HI;
            3'd7:    half_pat = PAT_REP_LO;
            default: half_pat = PAT_NONE;
        endcase
    end

    // Map the byte table index to a pattern.
    always_comb begin
        case (byte_idx)
            4'd1, 4'd6: byte_pat = PAT_MIX_HI;
            4'd2, 4'd7: byte_pat = PAT_MIX_LO;
            4'd3:       byte_pat = PAT_UNPK_SGN;
            4'd4:       byte_pat = PAT_PACK_HI;
            4'd5:       byte_pat = PAT_PACK_LO;
            default:    byte_pat = PAT_NONE;
        endcase
    end

    // Pick the table that the format bits name; anything else has no pattern.
    always_comb begin
        is_half = fmt_half;
        if (fmt_half)      pattern = half_pat;
        else if (fmt_byte) pattern = byte_pat;
        else               pattern = PAT_NONE;
        bad_code = (pattern == PAT_NONE);
    end

endmodule

// File: rtl/lsh_lane_route.sv
// Module: per-lane router. Each result lane selects a lane of the first or second
// source, or a sign fill of a first-source lane, according to the pattern.
// Assumes LANES is even; lane 0 is the least significant lane.
module lsh_lane_route
    import lsh_shuffle_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 8
) (
    input  pattern_e                  pattern,
    input  logic [LANES*LANE_W-1:0]   first,
    input  logic [LANES*LANE_W-1:0]   second,
    output logic [LANES*LANE_W-1:0]   routed
);

    localparam int HALF  = LANES / 2;
    localparam int IDX_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam bit EVEN = (i % 2) == 0;

        src_e              sel;
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] pick;

        // Work out source and lane index of result lane i.
        always_comb begin
            sel = SRC_FIRST;
            idx = '0;
            case (pattern)
                PAT_MIX_HI: begin
                    sel = EVEN ? SRC_SECOND : SRC_FIRST;
                    idx = IDX_W'(HALF + i / 2);
                end
                PAT_MIX_LO: begin
                    sel = EVEN ? SRC_SECOND : SRC_FIRST;
                    idx = IDX_W'(i / 2);
                end
                PAT_UNPK_SGN: begin
                    sel = EVEN ? SRC_FIRST : SRC_SIGN;
                    idx = IDX_W'(i / 2);
                end
                PAT_PACK_HI: begin
                    sel = (i < HALF) ? SRC_SECOND : SRC_FIRST;
                    idx = IDX_W'(2 * (i % HALF) + 1);
                end
                PAT_PACK_LO: begin
                    sel = (i < HALF) ? SRC_SECOND : SRC_FIRST;
                    idx = IDX_W'(2 * (i % HALF));
                end
                PAT_BFLY: begin
                    sel = EVEN ? SRC_SECOND : SRC_FIRST;
                    idx = EVEN ? IDX_W'(i + 1) : IDX_W'(i - 1);
                end
                PAT_REP_HI: begin
                    sel = (i < HALF) ? SRC_SECOND : SRC_FIRST;
                    idx = IDX_W'(HALF + i % HALF);
                end
                PAT_REP_LO: begin
                    sel = (i < HALF) ? SRC_SECOND : SRC_FIRST;
                    idx = IDX_W'(i % HALF);
                end
                default: begin
                    sel = SRC_FIRST;
                    idx = '0;
                end
            endcase
        end

        // Fetch the selected lane or build the sign fill.
        always_comb begin
            case (sel)
                SRC_SECOND: pick = second[idx*LANE_W +: LANE_W];
                SRC_SIGN:   pick = {LANE_W{first[idx*LANE_W + LANE_W - 1]}};
                default:    pick = first[idx*LANE_W +: LANE_W];
            endcase
        end

        assign routed[i*LANE_W +: LANE_W] = pick;
    end

endmodule

// File: rtl/lsh_shuffle_unit.sv
// Module: top of the packed lane shuffle network. Decodes the code, routes byte
// and halfword lanes in parallel, and selects the format result or zero.
// Assumes a purely combinational use; no clock or reset.
module lsh_shuffle_unit
    import lsh_shuffle_pkg::*;
(
    input  logic [CODE_W-1:0] shuf_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);

    logic              is_half;
    pattern_e          pattern;
    logic              bad_code;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] half_res;

    lsh_code_decode i_decode (
        .code     (shuf_code),
        .is_half  (is_half),
        .pattern  (pattern),
        .bad_code (bad_code)
    );

    lsh_lane_route #(.LANE_W(BYTE_W), .LANES(NBYTES)) i_byte_route (
        .pattern (pattern),
        .first   (src_a),
        .second  (src_b),
        .routed  (byte_res)
    );

    lsh_lane_route #(.LANE_W(HALF_W), .LANES(NHALVES)) i_half_route (
        .pattern (pattern),
        .first   (src_a),
        .second  (src_b),
        .routed  (half_res)
    );

    // Choose the format result; force zero on an illegal code.
    always_comb begin
        illegal = bad_code;
        if (bad_code)     result = '0;
        else if (is_half) result = half_res;
        else              result = byte_res;
    end

endmodule

// File: rtl/lsh_shuffle_chk.sv
// Module: checker bound to the shuffle unit; relates code, sources and result.
// Assumes combinational inputs that are stable while checked.
module lsh_shuffle_chk
    import lsh_shuffle_pkg::*;
(
    input logic [CODE_W-1:0] shuf_code,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] result,
    input logic              illegal
);

    // Check port relations whenever any input changes.
    always_comb begin
        // R2
        illegal_zero_chk: assert (!illegal || result == '0);
        // R1
        fmt_eleven_chk: assert (shuf_code[1:0] != 2'b11 || illegal);
        // R2
        byte_high_idx_chk: assert (!(shuf_code[0] == 1'b0 && shuf_code[4]) || illegal);
        // R10
        legal_flag_chk: assert (!(shuf_code == 5'h06 || shuf_code == 5'h01) || !illegal);
        // R3
        half_mixhi_chk: assert (shuf_code != 5'h01 || result[15:0] == src_b[47:32]);
        // R8
        sign_fill_chk: assert (shuf_code != 5'h06 || result[15:8] == {8{src_a[7]}});
        // R4
        bfly_chk: assert (shuf_code != 5'h11 || result[31:16] == src_a[15:0]);
    end

endmodule

bind lsh_shuffle_unit lsh_shuffle_chk i_shuffle_chk (
    .shuf_code (shuf_code),
    .src_a     (src_a),
    .src_b     (src_b),
    .result    (result),
    .illegal   (illegal)
);

// File: tb/test_lsh_shuffle_unit.sv
module test_lsh_shuffle_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] VA = 64'hA7A6A5A4A3A2A1A0;
    localparam logic [63:0] VB = 64'hB7B6B5B4B3B2B1B0;

    typedef struct packed {
        logic [4:0]  code;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{5'h01, VA, VB, 64'hA7A6B7B6A5A4B5B4, 1'b0, 8'd3},  // R3 mix high
        '{5'h05, VA, VB, 64'hA3A2B3B2A1A0B1B0, 1'b0, 8'd3},  // R3 mix low
        '{5'h09, VA, VB, 64'hA7A6A3A2B7B6B3B2, 1'b0, 8'd4},  // R4 pack high
        '{5'h11, VA, VB, 64'hA5A4B7B6A1A0B3B2, 1'b0, 8'd4},  // R4 butterfly
        '{5'h19, VA, VB, 64'hA7A6A5A4B7B6B5B4, 1'b0, 8'd5},  // R5 replicate high
        '{5'h1D, VA, VB, 64'hA3A2A1A0B3B2B1B0, 1'b0, 8'd5},  // R5 replicate low
        '{5'h02, VA, VB, 64'hA7B7A6B6A5B5A4B4, 1'b0, 8'd6},  // R6
        '{5'h0C, VA, VB, 64'hA7B7A6B6A5B5A4B4, 1'b0, 8'd6},  // R6
        '{5'h04, VA, VB, 64'hA3B3A2B2A1B1A0B0, 1'b0, 8'd6},  // R6
        '{5'h0E, VA, VB, 64'hA3B3A2B2A1B1A0B0, 1'b0, 8'd6},  // R6
        '{5'h08, VA, VB, 64'hA7A5A3A1B7B5B3B1, 1'b0, 8'd7},  // R7
        '{5'h0A, VA, VB, 64'hA6A4A2A0B6B4B2B0, 1'b0, 8'd7},  // R7
        '{5'h06, VA, VB, 64'hFFA3FFA2FFA1FFA0, 1'b0, 8'd8},  // R8
        '{5'h06, 64'h000000007F8001FF, VB, 64'h007FFF800001FFFF, 1'b0, 8'd9}, // R9 lane order
        '{5'h03, VA, VB, 64'h0, 1'b1, 8'd1},  // R1
        '{5'h07, VA, VB, 64'h0, 1'b1, 8'd1},  // R1
        '{5'h1F, VA, VB, 64'h0, 1'b1, 8'd1},  // R1
        '{5'h00, VA, VB, 64'h0, 1'b1, 8'd2},  // R2
        '{5'h0D, VA, VB, 64'h0, 1'b1, 8'd2},  // R2
        '{5'h15, VA, VB, 64'h0, 1'b1, 8'd2},  // R2
        '{5'h10, VA, VB, 64'h0, 1'b1, 8'd2},  // R2
        '{5'h1E, VA, VB, 64'h0, 1'b1, 8'd2}   // R2
    };

    logic        clk = 1'b0;
    logic [4:0]  shuf_code;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic [63:0] result;
    logic        illegal;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsh_shuffle_unit i_lsh_shuffle_unit (
        .shuf_code (shuf_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .result    (result),
        .illegal   (illegal)
    );

    task automatic check(input string req, input logic [63:0] got_r, input logic got_i,
                         input logic [63:0] exp_r, input logic exp_i);
        checks++;
        if (got_r !== exp_r || got_i !== exp_i) begin
            errors++;
            $display("FAIL %s code=%h result=%h illegal=%b expected result=%h illegal=%b",
                     req, shuf_code, got_r, got_i, exp_r, exp_i);
        end
    endtask

    task automatic apply(input logic [4:0] c, input logic [63:0] a, input logic [63:0] b);
        @(posedge clk);
        shuf_code = c;
        src_a     = a;
        src_b     = b;
        @(negedge clk);
    endtask

    // Legal code list from R1/R2/R10.
    function automatic logic code_legal(input logic [4:0] c);
        case (c)
            5'h01, 5'h05, 5'h09, 5'h11, 5'h19, 5'h1D,
            5'h02, 5'h04, 5'h06, 5'h08, 5'h0A, 5'h0C, 5'h0E: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        int nlegal;
        shuf_code = 5'h00;
        src_a     = VA;
        src_b     = VB;
        @(negedge clk);
        // R2 initial state: code 0 is reserved
        check("R2 initial", result, illegal, 64'h0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].code, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d", VECS[i].req), result, illegal, VECS[i].exp, VECS[i].ill);
        end

        // R8: second source has no effect on sign unpack
        apply(5'h06, 64'h000000007F8001FF, 64'h0123456789ABCDEF);
        check("R8 second ignored", result, illegal, 64'h007FFF800001FFFF, 1'b0);

        // R9: single low lane moves to expected position
        apply(5'h19, 64'h0, 64'h0000000000001234);
        check("R9 halfword lane0", result, illegal, 64'h0, 1'b0);
        apply(5'h1D, 64'h0, 64'h0000000000001234);
        check("R9 lane0 low bits", result, illegal, 64'h0000000000001234, 1'b0);

        // R10 and R2: sweep every code with all-ones sources
        nlegal = 0;
        for (int c = 0; c < 32; c++) begin
            apply(5'(c), '1, '1);
            if (code_legal(5'(c))) begin
                nlegal++;
                check("R10 sweep", result, illegal, '1, 1'b0);
            end else begin
                check("R2 sweep", result, illegal, 64'h0, 1'b1);
            end
        end
        checks++;
        if (nlegal != 13) begin
            errors++;
            $display("FAIL R10 legal count actual=%0d expected=13", nlegal);
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        while (!done && cycles < 10000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule